// File: doc/BRIEF.md
# Reset Release Controller

This block produces the active-low system reset and the auxiliary reset of a power-management controller. After an ON or WAKE start pulse it keeps the system reset asserted. It releases the reset once a programmable number of millisecond ticks has elapsed. The delay is picked from four uneven values. A low on the external reset input, after two synchronising flops, asserts the system reset at once. When that input returns high, the delay starts over.

In SLEEP both reset outputs take levels set by configuration bits, and a mask bit decides whether the external reset input still has an effect. A software-reset strobe either returns the configuration word to its defaults or leaves it alone, as a configuration bit selects. An ON start pulse can also raise a one-cycle request to reload the bootstrap configuration. The configuration word changes only while the security key input reports the key unlocked.

Top module: `rstc_top`

## Requirements
- R1: After power-on reset `sysRstN` is 0, `auxRst` is 0 and `reloadReq` is 0. Every configuration bit resets to 1, which gives a release delay of 101 ticks.
- R2: The configuration bits [6:5] select the release delay: 00 = 3, 01 = 11, 10 = 51 and 11 = 101 ticks. In ACTIVE, `sysRstN` goes to 1 at the clock edge that samples the last required tick after the start pulse.
- R3: A new `seqStart` pulse restarts the delay count from zero and drives `sysRstN` to 0 at the next edge in ACTIVE.
- R4: Outside SLEEP, a low on `extRstN` drives `sysRstN` to 0 two clock edges later. After `extRstN` returns high and has passed the two flops, the full selected delay runs again.
- R5: In SLEEP, configuration bit 4 sets the system reset: 1 gives `sysRstN` = 0 and 0 gives `sysRstN` = 1.
- R6: In SLEEP, configuration bit 3 = 1 makes the block ignore `extRstN`. With bit 3 = 0, a low on `extRstN` still drives `sysRstN` to 0.
- R7: In SLEEP `auxRst` equals configuration bit 2. Outside SLEEP `auxRst` is 0.
- R8: A `swRst` pulse returns the configuration word to all ones when configuration bit 1 is 0. When bit 1 is 1 the pulse leaves the word unchanged.
- R9: A `seqStart` pulse with `seqIsOn` = 1 gives `reloadReq` = 1 for exactly the next cycle, provided configuration bit 0 is 1. A pulse with `seqIsOn` = 0 does not raise it.
- R10: A write with `cfgWrEn` = 1 loads `cfgWrData` only when `keyUnlocked` = 1. Otherwise the write has no effect.
- R11: With `pwrState` = OFF (2'b00), `sysRstN` stays 0 and the delay count is held at zero. ACTIVE is 2'b01 and SLEEP is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| msTick | input | 1 | One-cycle millisecond tick |
| pwrState | input | 2 | 00 OFF, 01 ACTIVE, 10 SLEEP |
| seqStart | input | 1 | ON or WAKE start pulse |
| seqIsOn | input | 1 | 1 marks the start pulse as ON, 0 as WAKE |
| extRstN | input | 1 | External reset input, active low, asynchronous |
| swRst | input | 1 | Software-reset strobe |
| keyUnlocked | input | 1 | Security key unlocked |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 7 | Configuration word to write |
| sysRstN | output | 1 | System reset, active low |
| auxRst | output | 1 | Auxiliary reset, active high |
| reloadReq | output | 1 | One-cycle bootstrap reload request |

## Verification
The delay is measured by counting ticks between a start pulse and the release, for all four duration codes. This shows whether each code maps to its own count, and whether the release comes one tick early or late. Three kinds of restart are compared to show that each one clears the count: a start pulse given in the middle of a count, a pulse and release of the external reset, and a stay in OFF. The SLEEP tests try every value of the level bits and of the mask bit, so that a swapped bit or an inverted level shows up. Software reset is run with the keep bit both set and cleared, and the release delay that follows shows which configuration survived. A per-cycle model compares all outputs on every clock.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  typedef enum logic [1:0] {
    PWR_OFF    = 2'b00,
    PWR_ACTIVE = 2'b01,
    PWR_SLEEP  = 2'b10
  } pwr_state_e;

  localparam int CFG_W = 7;

  typedef struct packed {
    logic [1:0] durSel;    // bits 6:5
    logic       slpRstLvl; // bit 4
    logic       slpMask;   // bit 3
    logic       slpAuxLvl; // bit 2
    logic       swKeep;    // bit 1
    logic       reconfOn;  // bit 0
  } cfg_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic cfgLoad;
    logic cfgDefault;
  } ctl_strobe_t;
endpackage

// File: rtl/rstc_datapath.sv
module rstc_datapath
  import rstc_pkg::*;
#(
  parameter int unsigned DELAY0 = 3,
  parameter int unsigned DELAY1 = 11,
  parameter int unsigned DELAY2 = 51,
  parameter int unsigned DELAY3 = 101
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strobe,
  input  logic [CFG_W-1:0] wrData,
  output cfg_t             cfg,
  output logic             delayDone
);
  localparam int unsigned MAXD01 = (DELAY0 > DELAY1) ? DELAY0 : DELAY1;
  localparam int unsigned MAXD23 = (DELAY2 > DELAY3) ? DELAY2 : DELAY3;
  localparam int unsigned MAXD   = (MAXD01 > MAXD23) ? MAXD01 : MAXD23;
  localparam int CNT_W = $clog2(MAXD + 1);
  localparam logic [CFG_W-1:0] CFG_DEFAULT = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    unique case (cfg.durSel)
      2'b00:   limit = CNT_W'(DELAY0);
      2'b01:   limit = CNT_W'(DELAY1);
      2'b10:   limit = CNT_W'(DELAY2);
      default: limit = CNT_W'(DELAY3);
    endcase
  end

  assign cntNext = cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      delayDone <= 1'b0;
    end else if (strobe.cntClr) begin
      cnt       <= '0;
      delayDone <= 1'b0;
    end else if (strobe.cntInc && !delayDone) begin
      cnt       <= cntNext;
      delayDone <= (cntNext == limit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= cfg_t'(CFG_DEFAULT);
    end else if (strobe.cfgDefault) begin
      cfg <= cfg_t'(CFG_DEFAULT);
    end else if (strobe.cfgLoad) begin
      cfg <= cfg_t'(wrData);
    end
  end
endmodule

// File: rtl/rstc_control.sv
module rstc_control
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        msTick,
  input  logic [1:0]  pwrState,
  input  logic        seqStart,
  input  logic        seqIsOn,
  input  logic        extRstN,
  input  logic        swRst,
  input  logic        keyUnlocked,
  input  logic        cfgWrEn,
  input  cfg_t        cfg,
  input  logic        delayDone,
  output ctl_strobe_t strobe,
  output logic        sysRstN,
  output logic        auxRst,
  output logic        reloadReq
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic isOff, isActive, isSleep, extActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], extRstN};
  end

  assign isOff     = (pwrState == PWR_OFF);
  assign isActive  = (pwrState == PWR_ACTIVE);
  assign isSleep   = (pwrState == PWR_SLEEP);
  assign extActive = !syncQ[SYNC_STAGES-1] && !(isSleep && cfg.slpMask);

  always_comb begin
    strobe.cntClr     = isOff || seqStart || extActive;
    strobe.cntInc     = msTick;
    strobe.cfgDefault = swRst && !cfg.swKeep;
    strobe.cfgLoad    = cfgWrEn && keyUnlocked;
  end

  always_comb begin
    if (isSleep)       sysRstN = !(cfg.slpRstLvl || extActive);
    else if (isActive) sysRstN = delayDone && !extActive;
    else               sysRstN = 1'b0;
    auxRst = isSleep && cfg.slpAuxLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadReq <= 1'b0;
    else       reloadReq <= seqStart && seqIsOn && cfg.reconfOn;
  end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int unsigned DELAY0 = 3,
  parameter int unsigned DELAY1 = 11,
  parameter int unsigned DELAY2 = 51,
  parameter int unsigned DELAY3 = 101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic [1:0]       pwrState,
  input  logic             seqStart,
  input  logic             seqIsOn,
  input  logic             extRstN,
  input  logic             swRst,
  input  logic             keyUnlocked,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             sysRstN,
  output logic             auxRst,
  output logic             reloadReq
);
  ctl_strobe_t strobe;
  cfg_t        cfg;
  logic        delayDone;

  rstc_control #(.SYNC_STAGES(2)) ctl_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .pwrState(pwrState),
    .seqStart(seqStart), .seqIsOn(seqIsOn), .extRstN(extRstN),
    .swRst(swRst), .keyUnlocked(keyUnlocked), .cfgWrEn(cfgWrEn),
    .cfg(cfg), .delayDone(delayDone), .strobe(strobe),
    .sysRstN(sysRstN), .auxRst(auxRst), .reloadReq(reloadReq)
  );

  rstc_datapath #(
    .DELAY0(DELAY0), .DELAY1(DELAY1), .DELAY2(DELAY2), .DELAY3(DELAY3)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(cfgWrData),
    .cfg(cfg), .delayDone(delayDone)
  );
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwrState,
  input logic       seqStart,
  input logic       seqIsOn,
  input logic       extRstN,
  input logic       sysRstN,
  input logic       auxRst,
  input logic       reloadReq
);
  // R11
  off_holds_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b00) |-> !sysRstN);

  // R7
  aux_only_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    auxRst |-> (pwrState == 2'b10));

  // R9
  reload_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |-> $past(seqStart && seqIsOn));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(seqStart) && pwrState == 2'b01) |-> !sysRstN);

  // R4
  ext_assert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'b10 && !$past(extRstN, 2)) |-> !sysRstN);
endmodule

bind rstc_top rstc_chk chk_i (
  .clk(clk), .rstN(rstN), .pwrState(pwrState), .seqStart(seqStart),
  .seqIsOn(seqIsOn), .extRstN(extRstN), .sysRstN(sysRstN),
  .auxRst(auxRst), .reloadReq(reloadReq)
);

// File: tb/rstc_top_tb.sv
module rstc_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic [1:0] pwrState = 2'b00;
  logic       seqStart = 1'b0;
  logic       seqIsOn = 1'b0;
  logic       extRstN = 1'b1;
  logic       swRst = 1'b0;
  logic       keyUnlocked = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [6:0] cfgWrData = 7'd0;
  logic       sysRstN, auxRst, reloadReq;

  int checkCnt = 0;
  int failCnt = 0;
  string curReq = "R1";
  bit tickEn = 1'b0;
  int tickSeen = 0;

  always #4 clk = ~clk;

  rstc_top dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .pwrState(pwrState),
    .seqStart(seqStart), .seqIsOn(seqIsOn), .extRstN(extRstN),
    .swRst(swRst), .keyUnlocked(keyUnlocked), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .sysRstN(sysRstN), .auxRst(auxRst),
    .reloadReq(reloadReq)
  );

  // tick every 4 cycles, driven at negedge
  int tickDiv = 0;
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    msTick <= tickEn && (tickDiv == 0);
  end
  always @(posedge clk) if (rstN && msTick) tickSeen++;

  // behavioural reference model
  int   mS1 = 1, mS2 = 1, mTicks = 0, mDone = 0, mReload = 0;
  int   mCfg [7];
  initial for (int i = 0; i < 7; i++) mCfg[i] = 1;

  function automatic int limitOf(int d);
    if (d == 0) return 3;
    if (d == 1) return 11;
    if (d == 2) return 51;
    return 101;
  endfunction

  function automatic int extHits();
    return (mS2 == 0) && !(pwrState == 2'b10 && mCfg[3] == 1);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mTicks = 0; mDone = 0; mReload = 0;
      for (int i = 0; i < 7; i++) mCfg[i] = 1;
    end else begin
      int eh;
      int lim;
      eh = extHits();
      lim = limitOf(mCfg[6] * 2 + mCfg[5]);
      mReload = seqStart && seqIsOn && mCfg[0] == 1;
      if (pwrState == 2'b00 || seqStart || eh) begin
        mTicks = 0; mDone = 0;
      end else if (msTick && !mDone) begin
        mTicks++;
        if (mTicks == lim) mDone = 1;
      end
      if (swRst && mCfg[1] == 0) begin
        for (int i = 0; i < 7; i++) mCfg[i] = 1;
      end else if (cfgWrEn && keyUnlocked) begin
        for (int i = 0; i < 7; i++) mCfg[i] = cfgWrData[i];
      end
      mS2 = mS1; mS1 = extRstN;
    end
  end

  function automatic logic mSys();
    if (pwrState == 2'b10) return !(mCfg[4] == 1 || extHits());
    if (pwrState == 2'b01) return mDone == 1 && !extHits();
    return 1'b0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    check(curReq, "model sysRstN", sysRstN, mSys());
    check(curReq, "model auxRst", auxRst, (pwrState == 2'b10) && mCfg[2] == 1);
    check(curReq, "model reloadReq", reloadReq, mReload);
  end

  task automatic wrCfg(logic [6:0] d, logic key);
    keyUnlocked = key; cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; keyUnlocked = 1'b0;
  endtask

  int relSeen;
  task automatic startSeq(logic on);
    seqIsOn = on; seqStart = 1'b1;
    @(negedge clk);
    seqStart = 1'b0;
    relSeen = reloadReq;
  endtask

  task automatic measure(string req, int exp);
    int base;
    int guard;
    base = tickSeen;
    guard = 0;
    while (!sysRstN && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(req, "release ticks", tickSeen - base, exp);
  endtask

  initial begin
    #(200000 * 8);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "sysRstN", sysRstN, 0);
    check("R1", "auxRst", auxRst, 0);
    check("R1", "reloadReq", reloadReq, 0);
    rstN = 1'b1;
    tickEn = 1'b1;
    @(negedge clk);

    // R11 OFF holds reset
    curReq = "R11";
    startSeq(1'b1);
    repeat (500) @(negedge clk);
    check("R11", "sysRstN in OFF", sysRstN, 0);

    // R1 / R9 default delay and reload on ON
    curReq = "R9";
    pwrState = 2'b01;
    startSeq(1'b1);
    check("R9", "reload after ON", relSeen, 1);
    @(negedge clk);
    check("R9", "reload one cycle", reloadReq, 0);
    curReq = "R1";
    measure("R1", 100 - 0 + 1);

    // R2 each duration code; WAKE start gives no reload
    curReq = "R2";
    for (int d = 0; d < 4; d++) begin
      wrCfg({d[1:0], 5'b11111}, 1'b1);
      startSeq(1'b0);
      check("R9", "no reload on WAKE", relSeen, 0);
      measure("R2", limitOf(d));
    end

    // R3 restart mid-count (dur = 01, 11 ticks)
    curReq = "R3";
    wrCfg(7'b0111111, 1'b1);
    startSeq(1'b0);
    repeat (20) @(negedge clk);
    startSeq(1'b0);
    check("R3", "low after restart", sysRstN, 0);
    measure("R3", 11);

    // R10 locked write ignored
    curReq = "R10";
    wrCfg(7'b0011111, 1'b0);
    startSeq(1'b0);
    measure("R10", 11);

    // R4 external reset
    curReq = "R4";
    extRstN = 1'b0;
    @(negedge clk);
    check("R4", "one edge later", sysRstN, 1);
    @(negedge clk);
    check("R4", "two edges later", sysRstN, 0);
    repeat (10) @(negedge clk);
    extRstN = 1'b1;
    repeat (2) @(negedge clk);
    measure("R4", 11);

    // SLEEP levels
    curReq = "R5";
    pwrState = 2'b10;
    @(negedge clk);
    check("R5", "sleep rst level 1", sysRstN, 0);
    check("R7", "sleep aux level 1", auxRst, 1);
    wrCfg(7'b0101011, 1'b1); // rst 0, mask 1, aux 0
    check("R5", "sleep rst level 0", sysRstN, 1);
    check("R7", "sleep aux level 0", auxRst, 0);
    curReq = "R6";
    extRstN = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", "masked ext ignored", sysRstN, 1);
    wrCfg(7'b0100011, 1'b1); // mask 0
    @(negedge clk);
    check("R6", "unmasked ext acts", sysRstN, 0);
    extRstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", "ext released", sysRstN, 1);
    pwrState = 2'b01;
    @(negedge clk);
    check("R7", "aux off in ACTIVE", auxRst, 0);

    // R8 software reset
    curReq = "R8";
    wrCfg(7'b0011111, 1'b1); // keep = 1, dur 00
    swRst = 1'b1; @(negedge clk); swRst = 1'b0;
    startSeq(1'b0);
    measure("R8", 3);
    wrCfg(7'b0011101, 1'b1); // keep = 0, dur 00
    swRst = 1'b1; @(negedge clk); swRst = 1'b0;
    startSeq(1'b0);
    measure("R8", 101);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule